// File: doc/BRIEF.md
# Vectored Interrupt Controller with Peripheral Aggregation

This block gathers interrupt requests for a small 8-bit processor core and steers them to one of four fixed vector addresses. Three vectors each belong to a single dedicated source: an external interrupt pin, a timer-0 overflow, and a timer-0 clock-input edge. The fourth vector is shared by fourteen peripheral sources. Each peripheral source has a flag and an enable, held in two flag/enable register groups. The masked peripheral flags are merged into one peripheral-pending indication, and a peripheral-enable bit gates that indication.

Every source enters as a one-cycle set pulse. The flag is latched whatever the enables or the global-disable bit hold. The core sees a registered request. It answers with an acknowledge pulse, and on that cycle the block captures the vector address of the highest-priority qualified source and sets the global-disable bit. If the source is dedicated, the block also clears that source's flag. Peripheral flags stay set until software clears them. A return strobe clears the global-disable bit again. A wake-up output is high whenever any qualified source is pending, whatever the global-disable state. Software reads and writes the flags, the enables and the global-disable bit through a small register port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every flag and every enable is 0, the global-disable bit is 1, `irq_req` and `wake` are 0, and `vec_addr` is 0.
- R2: A set pulse makes its flag read back as 1 from the next cycle on, even when its enable is 0 and the global-disable bit is 1.
- R3: Status bit 3 (address 1) reads 1 while any peripheral flag is set together with its enable, regardless of the peripheral-enable bit. The shared vector is requested only when control bit 3 (peripheral enable) is also 1.
- R4: `irq_req` is registered. It is 1 in a cycle exactly when, in the previous cycle, some qualified source was pending, the global-disable bit was 0, and `irq_ack` was 0.
- R5: An `irq_ack` pulse sets the global-disable bit (control bit 4) for the following cycle and drops `irq_req`.
- R6: On `irq_ack` the vector is chosen by fixed priority: external pin, then timer-0 overflow, then timer-0 clock edge, then peripherals (also chosen when nothing is pending). From the next cycle `vec_addr` holds VEC_BASE + index*VEC_STEP, which by default gives 0x08, 0x10, 0x18 and 0x20.
- R7: Acknowledging a dedicated vector clears only that source's flag. Acknowledging the shared vector clears no peripheral flag, so the request returns after a return strobe until software clears the flag.
- R8: When a set pulse arrives in the same cycle as a software write or an auto-clear that would clear the same flag, the flag ends up set.
- R9: `irq_ret` clears the global-disable bit. Within one cycle an acknowledge takes precedence over a return, and a return takes precedence over a register write.
- R10: `wake` is 1 whenever a qualified source is pending (dedicated flag with its enable, or peripheral pending with peripheral enable), independent of the global-disable bit.
- R11: Register map, read back combinationally. Address 0 is control: bits 0..3 are the external, timer-0 overflow, timer-0 edge and peripheral enables, bit 4 is global disable. Address 1 is status: bits 0..2 are the dedicated flags, bit 3 is peripheral pending (read only). Address 2 is the group A flags and address 3 the group A enables (`per_set[7:0]`). Address 4 is the group B flags and address 5 the group B enables (`per_set[13:8]`). All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_set | input | 1 | External pin event pulse |
| tov_set | input | 1 | Timer-0 overflow pulse |
| tclk_set | input | 1 | Timer-0 clock-input edge pulse |
| per_set | input | GRP_A_W+GRP_B_W | Peripheral event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Registered interrupt request |
| vec_addr | output | ADDR_W | Vector captured at the last acknowledge |
| wake | output | 1 | Wake-up / end-long-write request |

## Verification
The bench builds the block with its default parameters: an 8-bit peripheral group A, a 6-bit group B, and vectors at 0x08 to 0x20. With these values all fourteen peripheral bits and both register groups can be reached from one random stimulus stream. Directed sequences walk the priority chain one vector at a time. They also collide set pulses with clearing writes and with acknowledges, and they show that an uncleared peripheral flag fires again. A long random phase then mixes acknowledges, returns, writes and set pulses, and compares every output against a behavioural model on every cycle.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    typedef enum logic [1:0] {
        VEC_EXT = 2'd0,
        VEC_TOV = 2'd1,
        VEC_TCK = 2'd2,
        VEC_PER = 2'd3
    } vec_sel_e;

    localparam int unsigned REG_ADDR_W = 3;
    localparam int unsigned REG_DATA_W = 8;
    localparam int unsigned N_VEC      = 4;

    localparam logic [REG_ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_FLGA = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_ENA  = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_FLGB = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_ENB  = 3'd5;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         flag_wr_i,
    input  logic         en_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] en_o,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (flag_wr_i) bank_d.flag = wdata_i;
        if (en_wr_i)   bank_d.en   = wdata_i;
        // a hardware event overrides any clearing write in the same cycle
        bank_d.flag = bank_d.flag | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flag_o = bank_q.flag;
    assign en_o   = bank_q.en;
    assign hit_o  = |(bank_q.flag & bank_q.en);

    // R8: an event pulse always leaves its flag set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    // R7: without a software write no flag is ever cleared here
    p_no_hw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr_i |=> (($past(flag_o) & ~flag_o) == '0));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_vec_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned VEC_BASE = 8,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic [N_VEC-1:0]  qual_i,
    output vec_sel_e          sel_o,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        sel_o = VEC_PER;
        for (int i = N_VEC - 1; i >= 0; i--) begin
            if (qual_i[i]) sel_o = vec_sel_e'(i);
        end
    end

    assign addr_o = ADDR_W'(VEC_BASE + 32'(sel_o) * VEC_STEP);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned GRP_A_W  = 8,
    parameter int unsigned GRP_B_W  = 6,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned VEC_BASE = 8,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ext_set,
    input  logic                       tov_set,
    input  logic                       tclk_set,
    input  logic [GRP_A_W+GRP_B_W-1:0] per_set,
    input  logic                       reg_wr,
    input  logic [REG_ADDR_W-1:0]      reg_addr,
    input  logic [REG_DATA_W-1:0]      reg_wdata,
    output logic [REG_DATA_W-1:0]      reg_rdata,
    input  logic                       irq_ack,
    input  logic                       irq_ret,
    output logic                       irq_req,
    output logic [ADDR_W-1:0]          vec_addr,
    output logic                       wake
);
    localparam int unsigned PER_W = GRP_A_W + GRP_B_W;
    localparam int unsigned N_DED = N_VEC - 1;

    typedef struct packed {
        logic [N_VEC-1:0]  en;     // ext, tov, tclk, peripheral
        logic [N_DED-1:0]  dflag;  // ext, tov, tclk
        logic              gdis;
        logic              req;
        logic [ADDR_W-1:0] vec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [GRP_A_W-1:0] flg_a, en_a;
    logic [GRP_B_W-1:0] flg_b, en_b;
    logic               hit_a, hit_b, per_pend;
    logic [N_VEC-1:0]   qual;
    vec_sel_e           sel;
    logic [ADDR_W-1:0]  sel_addr;
    logic               wr_ctrl, wr_stat;

    irq_flag_bank #(.W(GRP_A_W)) i_bank_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (per_set[GRP_A_W-1:0]),
        .flag_wr_i(reg_wr && reg_addr == A_FLGA),
        .en_wr_i  (reg_wr && reg_addr == A_ENA),
        .wdata_i  (reg_wdata[GRP_A_W-1:0]),
        .flag_o   (flg_a),
        .en_o     (en_a),
        .hit_o    (hit_a)
    );

    irq_flag_bank #(.W(GRP_B_W)) i_bank_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (per_set[PER_W-1:GRP_A_W]),
        .flag_wr_i(reg_wr && reg_addr == A_FLGB),
        .en_wr_i  (reg_wr && reg_addr == A_ENB),
        .wdata_i  (reg_wdata[GRP_B_W-1:0]),
        .flag_o   (flg_b),
        .en_o     (en_b),
        .hit_o    (hit_b)
    );

    assign per_pend = hit_a | hit_b;
    assign qual     = {per_pend & ctl_q.en[3], ctl_q.dflag & ctl_q.en[N_DED-1:0]};

    irq_prio_sel #(
        .ADDR_W  (ADDR_W),
        .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP)
    ) i_prio (
        .qual_i(qual),
        .sel_o (sel),
        .addr_o(sel_addr)
    );

    assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
    assign wr_stat = reg_wr && reg_addr == A_STAT;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.en   = reg_wdata[N_VEC-1:0];
            ctl_d.gdis = reg_wdata[4];
        end
        if (wr_stat) ctl_d.dflag = reg_wdata[N_DED-1:0];
        if (irq_ret) ctl_d.gdis = 1'b0;
        if (irq_ack) begin
            ctl_d.gdis = 1'b1;
            ctl_d.vec  = sel_addr;
            if (sel != VEC_PER) ctl_d.dflag[sel] = 1'b0;
        end
        ctl_d.dflag = ctl_d.dflag | {tclk_set, tov_set, ext_set};
        ctl_d.req   = (|qual) & ~ctl_q.gdis & ~irq_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.gdis <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[4:0]         = {ctl_q.gdis, ctl_q.en};
            A_STAT: reg_rdata[3:0]         = {per_pend, ctl_q.dflag};
            A_FLGA: reg_rdata[GRP_A_W-1:0] = flg_a;
            A_ENA:  reg_rdata[GRP_A_W-1:0] = en_a;
            A_FLGB: reg_rdata[GRP_B_W-1:0] = flg_b;
            A_ENB:  reg_rdata[GRP_B_W-1:0] = en_b;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_req  = ctl_q.req;
    assign vec_addr = ctl_q.vec;
    assign wake     = |qual;

    // R5: acceptance blocks further interrupts on the next cycle
    p_ack_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (ctl_q.gdis && !irq_req));

    // R9: a return without acknowledge re-enables interrupts
    p_ret_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack) |=> !ctl_q.gdis);

    // R4: a request only follows an enabled, unacknowledged cycle
    p_req_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!$past(ctl_q.gdis) && !$past(irq_ack)));

    // R7: taking the external vector drops its flag unless re-set
    p_ext_autoclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && sel == VEC_EXT && !ext_set && !wr_stat) |=> !ctl_q.dflag[0]);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_set = 0, tov_set = 0, tclk_set = 0;
    logic [13:0] per_set = '0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_ack = 0, irq_ret = 0;
    logic        irq_req, wake;
    logic [15:0] vec_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_set(ext_set), .tov_set(tov_set),
        .tclk_set(tclk_set), .per_set(per_set), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
        .vec_addr(vec_addr), .wake(wake)
    );

    // behavioural reference model
    bit [3:0] m_en;  bit [2:0] m_df;  bit m_gd, m_req;
    bit [7:0] m_fa, m_ea;  bit [5:0] m_fb, m_eb;  int m_vec;

    function automatic bit m_pend();
        return (|(m_fa & m_ea)) || (|(m_fb & m_eb));
    endfunction

    function automatic bit [3:0] m_qual();
        bit [3:0] r;
        for (int i = 0; i < 3; i++) r[i] = m_df[i] & m_en[i];
        r[3] = m_pend() & m_en[3];
        return r;
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return {m_gd, m_en};
            1: return {m_pend(), m_df};
            2: return m_fa;
            3: return m_ea;
            4: return m_fb;
            5: return m_eb;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_df = 0; m_gd = 1; m_req = 0;
            m_fa = 0; m_ea = 0; m_fb = 0; m_eb = 0; m_vec = 0;
        end else begin
            bit [3:0] q;  bit any;  int idx;
            q = m_qual();  any = |q;
            m_req = any && !m_gd && !irq_ack;
            if (reg_wr) begin
                case (reg_addr)
                    0: begin m_en = reg_wdata[3:0]; m_gd = reg_wdata[4]; end
                    1: m_df = reg_wdata[2:0];
                    2: m_fa = reg_wdata;
                    3: m_ea = reg_wdata;
                    4: m_fb = reg_wdata[5:0];
                    5: m_eb = reg_wdata[5:0];
                    default: ;
                endcase
            end
            if (irq_ret) m_gd = 0;
            if (irq_ack) begin
                idx = 3;
                for (int i = 3; i >= 0; i--) if (q[i]) idx = i;
                m_vec = 8 + 8 * idx;
                m_gd = 1;
                if (idx < 3) m_df[idx] = 0;
            end
            m_df = m_df | {tclk_set, tov_set, ext_set};
            m_fa = m_fa | per_set[7:0];
            m_fb = m_fb | per_set[13:8];
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        if (!rst_n) return;
        chk("R4 irq_req", int'(irq_req), int'(m_req));
        chk("R10 wake", int'(wake), int'(|m_qual()));
        chk("R6 vec_addr", int'(vec_addr), m_vec);
        chk("R11 reg_rdata", int'(reg_rdata), m_read(int'(reg_addr)));
    endtask

    task automatic tick();
        @(posedge clk); #1;
        compare();
    endtask

    task automatic idle();
        ext_set = 0; tov_set = 0; tclk_set = 0; per_set = '0;
        reg_wr = 0; irq_ack = 0; irq_ret = 0;
    endtask

    task automatic wr(int a, int v);
        reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(v);
        tick();
        reg_wr = 0;
    endtask

    task automatic rd_expect(int a, int exp, string tag);
        reg_addr = 3'(a); #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R1 reset state
        rd_expect(0, 8'h10, "R1 ctrl");
        rd_expect(1, 0, "R1 stat");
        rd_expect(2, 0, "R1 flags A");
        chk("R1 req", int'(irq_req), 0);
        chk("R1 wake", int'(wake), 0);
        chk("R1 vec", int'(vec_addr), 0);

        // R2 flag latches with enable off and global disable on
        ext_set = 1; tick(); ext_set = 0;
        rd_expect(1, 8'h01, "R2 ext flag");
        per_set[0] = 1; tick(); per_set = '0;
        rd_expect(2, 8'h01, "R2 periph flag");
        wr(2, 0);

        // R10 wake independent of global disable
        wr(0, 8'h11);
        chk("R10 wake while disabled", int'(wake), 1);
        tick();
        chk("R4 no req while disabled", int'(irq_req), 0);
        wr(0, 8'h01);
        tick();
        chk("R4 req after enable", int'(irq_req), 1);

        // R5 / R6 / R7 acknowledge of the external vector
        irq_ack = 1; tick(); irq_ack = 0;
        chk("R5 req drops", int'(irq_req), 0);
        chk("R6 ext vector", int'(vec_addr), 16'h0008);
        rd_expect(0, 8'h11, "R5 gdis set");
        rd_expect(1, 0, "R7 ext flag auto-cleared");

        // R9 return clears global disable
        irq_ret = 1; tick(); irq_ret = 0;
        rd_expect(0, 8'h01, "R9 gdis cleared");
        // R9 ack wins over return in one cycle
        irq_ack = 1; irq_ret = 1; tick(); idle();
        rd_expect(0, 8'h11, "R9 ack beats return");

        // R6 priority walk; R7 peripheral flag survives
        wr(3, 8'h08);
        wr(0, 8'h1F);
        tov_set = 1; tclk_set = 1; per_set[3] = 1; tick(); idle();
        for (int k = 0; k < 4; k++) begin
            irq_ret = 1; tick(); irq_ret = 0;
            tick();
            chk("R4 req per vector", int'(irq_req), 1);
            irq_ack = 1; tick(); irq_ack = 0;
            chk("R6 priority vector", int'(vec_addr), 16 + 8 * (k > 2 ? 2 : k));
        end
        rd_expect(2, 8'h08, "R7 periph flag kept");
        wr(2, 0);
        irq_ret = 1; tick(); irq_ret = 0;
        tick();
        chk("R7 no req after sw clear", int'(irq_req), 0);

        // R3 pending without peripheral enable
        wr(5, 8'h02);
        wr(0, 8'h07);
        per_set[9] = 1; tick(); per_set = '0;
        rd_expect(1, 8'h08, "R3 pending bit");
        tick();
        chk("R3 no req when periph disabled", int'(irq_req), 0);
        wr(0, 8'h0F);
        tick();
        chk("R3 req when periph enabled", int'(irq_req), 1);

        // R8 set beats clearing write and auto-clear
        reg_wr = 1; reg_addr = 3'd4; reg_wdata = 0; per_set[9] = 1;
        tick(); idle();
        rd_expect(4, 8'h02, "R8 set beats write");
        wr(4, 0);
        ext_set = 1; tick(); ext_set = 0;
        tick();
        ext_set = 1; irq_ack = 1; tick(); idle();
        chk("R8 ext vector taken", int'(vec_addr), 16'h0008);
        rd_expect(1, 8'h01, "R8 set beats auto-clear");

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            ext_set  = ($urandom_range(0, 15) == 0);
            tov_set  = ($urandom_range(0, 15) == 0);
            tclk_set = ($urandom_range(0, 15) == 0);
            per_set  = ($urandom_range(0, 3) == 0) ? 14'(1 << $urandom_range(0, 13)) : '0;
            reg_wr   = ($urandom_range(0, 5) == 0);
            reg_addr = 3'($urandom_range(0, 7));
            reg_wdata = 8'($urandom);
            irq_ack  = irq_req ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 40) == 0);
            irq_ret  = ($urandom_range(0, 6) == 0);
            tick();
        end
        idle();
        tick();
        summary();
    end
endmodule